// File: doc/BRIEF.md
# Management-mode sideband controller

This block is system-side glue between a processor and its memory controller. It watches the processor's management interrupt request and management-mode acknowledge. From them it conditions four sideband signals: the address-bit-20 mask sent back to the processor, the soft reset sent to the processor, a write-back-all pulse to the cache, and a select that tells the memory decoder to use management RAM or normal memory.

The raw active-low inputs from the processor side pass through a two-stage synchronizer. The snoop write-back flag and the management-RAM window hit come from the memory controller's own clock domain and are used directly. The two configuration bits are static straps. One says whether management RAM overlays normal memory, and the other says whether that overlaid memory is cacheable. Every output comes straight from a flip-flop.

The block tracks a management window. The window opens when the request is seen and closes when the acknowledge goes away. While the window is open, the address mask is forced off and soft-reset requests are held back. A held request is then delivered as one pulse when the window closes.

Top module: `mgmt_sideband_ctrl`

## Requirements
- R1: While the synchronized acknowledge is active (`mgmt_ack_n_i` low), `addr20_mask_n_o` is 1, whatever `addr20_req_n_i` is.
- R2: Outside the window, `addr20_mask_n_o` follows `addr20_req_n_i` three clocks after an input change. A request edge (`mgmt_irq_n_i` falling) forces it to 1 with the same three-clock latency. It returns to the requested level four clocks after `mgmt_ack_n_i` rises.
- R3: Outside the window, a falling edge of `soft_rst_req_n_i` gives `soft_rst_o` high for exactly one clock, three clocks after the edge. Holding the request low gives no further pulse.
- R4: A soft-reset request made between the management request and the acknowledge going away gives no pulse inside that span. It gives one pulse three clocks after `mgmt_ack_n_i` rises.
- R5: Several soft-reset requests inside one window merge into a single pulse at window exit.
- R6: With `cfg_overlay_i` = 1 and `cfg_cacheable_i` = 1, a falling edge of `mgmt_irq_n_i` drives `cache_wb_all_n_o` low for exactly one clock, three clocks after the edge.
- R7: If either configuration bit is 0, `cache_wb_all_n_o` stays 1 through management entry.
- R8: When `snoop_wb_i` is 1, `sel_protram_o` is 0 on the next clock, even during management mode.
- R9: One clock after the inputs, `sel_protram_o` equals `protram_hit_i & ~snoop_wb_i` when the synchronized acknowledge is active, and 0 when it is not.
- R10: Synchronous reset `rst` drives `addr20_mask_n_o` = 1, `soft_rst_o` = 0, `cache_wb_all_n_o` = 1 and `sel_protram_o` = 0. It also discards a held soft-reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mgmt_irq_n_i | input | 1 | Management interrupt request, active low, asynchronous |
| mgmt_ack_n_i | input | 1 | Processor's management-mode acknowledge, active low, asynchronous |
| addr20_req_n_i | input | 1 | Legacy address-bit-20 mask request, active low, asynchronous |
| soft_rst_req_n_i | input | 1 | Soft reset request, active low, asynchronous |
| snoop_wb_i | input | 1 | Current memory cycle is a snoop write-back |
| protram_hit_i | input | 1 | Current cycle address lies in the management RAM window |
| cfg_overlay_i | input | 1 | Management RAM overlays normal memory |
| cfg_cacheable_i | input | 1 | Overlaid normal memory is cacheable |
| addr20_mask_n_o | output | 1 | Gated address-bit-20 mask to the processor, active low |
| soft_rst_o | output | 1 | Gated soft reset pulse, active high |
| cache_wb_all_n_o | output | 1 | Single-clock write-back-all pulse, active low |
| sel_protram_o | output | 1 | 1 selects management RAM, 0 selects normal memory |

## Verification
The bench holds soft-reset requests inside a window and counts the pulses after exit. A design that lets a request through during the window, or that emits one pulse per request, shows up as extra or early pulses. It issues snoop write-backs that hit the management RAM window during management mode; a decoder that ignores the snoop flag would steer them into management RAM. It tries each configuration pair on entry, which catches a flush gated by only one strap. It also samples the address mask in the clock after the acknowledge is released, where an early unmask would corrupt the state restore.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  typedef enum logic [1:0] {
    WIN_IDLE   = 2'd0,
    WIN_ARMED  = 2'd1,
    WIN_ACTIVE = 2'd2
  } win_state_t;

  localparam int unsigned SYNC_STAGES_DEF = 2;
  localparam int unsigned N_ASYNC         = 4;
  localparam int unsigned IDX_IRQ         = 0;
  localparam int unsigned IDX_ACK         = 1;
  localparam int unsigned IDX_A20         = 2;
  localparam int unsigned IDX_SRST        = 3;
endpackage

// File: rtl/mgmt_sync.sv
module mgmt_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[LAST];
endmodule

// File: rtl/mgmt_window.sv
module mgmt_window
  import mgmt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic irq_s,
  input  logic ack_s,
  input  logic a20_req_s,
  input  logic srst_req_s,
  output logic a20_mask_n_q,
  output logic soft_rst_q
);
  win_state_t state_q, state_d;
  logic       srst_prev_q;
  logic       pend_q;
  logic       srst_edge;
  logic       window_c;
  logic       exit_c;
  logic       fire_c;

  assign srst_edge = srst_req_s & ~srst_prev_q;
  assign window_c  = (state_q != WIN_IDLE) | irq_s | ack_s;
  assign exit_c    = (state_q == WIN_ACTIVE) & ~ack_s;
  assign fire_c    = (srst_edge & ~window_c) | (exit_c & (pend_q | srst_edge));

  always_comb begin
    state_d = state_q;
    case (state_q)
      WIN_IDLE: begin
        if (ack_s)      state_d = WIN_ACTIVE;
        else if (irq_s) state_d = WIN_ARMED;
      end
      WIN_ARMED:  if (ack_s)  state_d = WIN_ACTIVE;
      WIN_ACTIVE: if (!ack_s) state_d = WIN_IDLE;
      default:    state_d = WIN_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= WIN_IDLE;
      srst_prev_q  <= 1'b0;
      pend_q       <= 1'b0;
      a20_mask_n_q <= 1'b1;
      soft_rst_q   <= 1'b0;
    end else begin
      state_q      <= state_d;
      srst_prev_q  <= srst_req_s;
      if (exit_c)                      pend_q <= 1'b0;
      else if (srst_edge && window_c)  pend_q <= 1'b1;
      a20_mask_n_q <= window_c ? 1'b1 : ~a20_req_s;
      soft_rst_q   <= fire_c;
    end
  end

  // R1: acknowledge active forces the mask inactive on the next edge
  p_ack_unmask_r1: assert property (@(posedge clk) disable iff (rst)
    ack_s |=> a20_mask_n_q);

  // R4: no soft reset escapes while the window is held open
  p_hold_blocked_r4: assert property (@(posedge clk) disable iff (rst)
    ((state_q == WIN_ARMED) || ((state_q == WIN_ACTIVE) && ack_s)) |=> !soft_rst_q);

  // R5: the held request is consumed at exit
  p_pend_clear_r5: assert property (@(posedge clk) disable iff (rst)
    exit_c |=> !pend_q);
endmodule

// File: rtl/mgmt_flush.sv
module mgmt_flush (
  input  logic clk,
  input  logic rst,
  input  logic irq_s,
  input  logic cfg_overlay,
  input  logic cfg_cacheable,
  output logic flush_n_q
);
  logic irq_prev_q;
  logic irq_edge;

  assign irq_edge = irq_s & ~irq_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_prev_q <= 1'b0;
      flush_n_q  <= 1'b1;
    end else begin
      irq_prev_q <= irq_s;
      flush_n_q  <= ~(irq_edge & cfg_overlay & cfg_cacheable);
    end
  end

  // R6: the pulse lasts one clock only
  p_flush_width_r6: assert property (@(posedge clk) disable iff (rst)
    !flush_n_q |=> flush_n_q);

  // R7: no pulse unless both straps are set
  p_flush_cfg_r7: assert property (@(posedge clk) disable iff (rst)
    !(cfg_overlay && cfg_cacheable) |=> flush_n_q);
endmodule

// File: rtl/mgmt_steer.sv
module mgmt_steer (
  input  logic clk,
  input  logic rst,
  input  logic ack_s,
  input  logic snoop_wb,
  input  logic prot_hit,
  output logic sel_prot_q
);
  always_ff @(posedge clk) begin
    if (rst) sel_prot_q <= 1'b0;
    else     sel_prot_q <= ack_s & prot_hit & ~snoop_wb;
  end

  // R8: snoop write-backs always land in normal memory
  p_snoop_normal_r8: assert property (@(posedge clk) disable iff (rst)
    snoop_wb |=> !sel_prot_q);

  // R9: outside management mode only normal memory is selected
  p_outside_normal_r9: assert property (@(posedge clk) disable iff (rst)
    !ack_s |=> !sel_prot_q);
endmodule

// File: rtl/mgmt_sideband_ctrl.sv
module mgmt_sideband_ctrl
  import mgmt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic mgmt_irq_n_i,
  input  logic mgmt_ack_n_i,
  input  logic addr20_req_n_i,
  input  logic soft_rst_req_n_i,
  input  logic snoop_wb_i,
  input  logic protram_hit_i,
  input  logic cfg_overlay_i,
  input  logic cfg_cacheable_i,
  output logic addr20_mask_n_o,
  output logic soft_rst_o,
  output logic cache_wb_all_n_o,
  output logic sel_protram_o
);
  logic [N_ASYNC-1:0] raw_act;
  logic [N_ASYNC-1:0] sync_act;

  assign raw_act[IDX_IRQ]  = ~mgmt_irq_n_i;
  assign raw_act[IDX_ACK]  = ~mgmt_ack_n_i;
  assign raw_act[IDX_A20]  = ~addr20_req_n_i;
  assign raw_act[IDX_SRST] = ~soft_rst_req_n_i;

  mgmt_sync #(.WIDTH(N_ASYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (raw_act),
    .q_o (sync_act)
  );

  mgmt_window u_window (
    .clk          (clk),
    .rst          (rst),
    .irq_s        (sync_act[IDX_IRQ]),
    .ack_s        (sync_act[IDX_ACK]),
    .a20_req_s    (sync_act[IDX_A20]),
    .srst_req_s   (sync_act[IDX_SRST]),
    .a20_mask_n_q (addr20_mask_n_o),
    .soft_rst_q   (soft_rst_o)
  );

  mgmt_flush u_flush (
    .clk           (clk),
    .rst           (rst),
    .irq_s         (sync_act[IDX_IRQ]),
    .cfg_overlay   (cfg_overlay_i),
    .cfg_cacheable (cfg_cacheable_i),
    .flush_n_q     (cache_wb_all_n_o)
  );

  mgmt_steer u_steer (
    .clk        (clk),
    .rst        (rst),
    .ack_s      (sync_act[IDX_ACK]),
    .snoop_wb   (snoop_wb_i),
    .prot_hit   (protram_hit_i),
    .sel_prot_q (sel_protram_o)
  );
endmodule

// File: tb/test_mgmt_sideband_ctrl.sv
module test_mgmt_sideband_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic irq_n = 1'b1, ack_n = 1'b1, a20_n = 1'b1, srst_n = 1'b1;
  logic snoop = 1'b0, hit = 1'b0, cfg_ov = 1'b0, cfg_ca = 1'b0;
  logic a20m_n, srst_o, flush_n, sel;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  mgmt_sideband_ctrl i_mgmt_sideband_ctrl (
    .clk (clk), .rst (rst),
    .mgmt_irq_n_i (irq_n), .mgmt_ack_n_i (ack_n),
    .addr20_req_n_i (a20_n), .soft_rst_req_n_i (srst_n),
    .snoop_wb_i (snoop), .protram_hit_i (hit),
    .cfg_overlay_i (cfg_ov), .cfg_cacheable_i (cfg_ca),
    .addr20_mask_n_o (a20m_n), .soft_rst_o (srst_o),
    .cache_wb_all_n_o (flush_n), .sel_protram_o (sel)
  );

  function automatic logic exp_sel(input logic in_mgmt, input logic h, input logic sn);
    return in_mgmt & h & ~sn;
  endfunction

  function automatic logic exp_flush_n(input logic ov, input logic ca);
    return ~(ov & ca);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic enter_mgmt();
    irq_n = 1'b0; tick(4);
    ack_n = 1'b0; tick(3);
    irq_n = 1'b1; tick(3);
  endtask

  task automatic leave_mgmt();
    ack_n = 1'b1; tick(5);
  endtask

  task automatic srst_pulse();
    srst_n = 1'b0; tick(2);
    srst_n = 1'b1; tick(3);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int cnt;
    logic p1, p2;
    void'($urandom(32'd4242));
    tick(4);
    // R10 reset state
    chk("R10 mask", a20m_n, 1); chk("R10 srst", srst_o, 0);
    chk("R10 flush", flush_n, 1); chk("R10 sel", sel, 0);
    rst = 1'b0; tick(2);

    // R2 mask follows request outside the window
    a20_n = 1'b0; tick(2); chk("R2 latency", a20m_n, 1);
    tick(1); chk("R2 follow", a20m_n, 0);

    // R6 flush on entry with both straps
    cfg_ov = 1'b1; cfg_ca = 1'b1;
    irq_n = 1'b0; tick(2); chk("R6 early", flush_n, 1);
    tick(1); chk("R6 pulse", flush_n, exp_flush_n(cfg_ov, cfg_ca));
    chk("R2 mask on request", a20m_n, 1);
    tick(1); chk("R6 width", flush_n, 1);
    tick(1); ack_n = 1'b0; tick(3);
    chk("R1 mask held", a20m_n, 1);
    irq_n = 1'b1; tick(1);

    // R4/R5 requests inside the window
    cnt = 0;
    for (int k = 0; k < 2; k++) begin
      srst_n = 1'b0;
      for (int j = 0; j < 3; j++) begin tick(1); cnt += srst_o; end
      srst_n = 1'b1;
      for (int j = 0; j < 4; j++) begin tick(1); cnt += srst_o; end
    end
    chk("R4 blocked", cnt, 0);

    // R8/R9 directed steering in management mode
    hit = 1'b1; snoop = 1'b0; tick(1); chk("R9 select", sel, 1);
    snoop = 1'b1; tick(1); chk("R8 snoop", sel, 0);
    hit = 1'b0; snoop = 1'b0; tick(1);

    // exit: one merged pulse, mask restored afterwards
    ack_n = 1'b1; tick(2); chk("R4 not yet", srst_o, 0);
    tick(1); chk("R4 delivered", srst_o, 1);
    chk("R2 held at exit", a20m_n, 1);
    tick(1); chk("R2 restored", a20m_n, 0);
    cnt = srst_o;
    for (int j = 0; j < 8; j++) begin tick(1); cnt += srst_o; end
    chk("R5 merged", cnt, 0);

    // R7 each single strap gives no flush
    for (int c = 0; c < 2; c++) begin
      cfg_ov = (c == 0); cfg_ca = (c != 0);
      irq_n = 1'b0; cnt = 0;
      for (int j = 0; j < 6; j++) begin tick(1); cnt += (flush_n == exp_flush_n(cfg_ov, cfg_ca)) ? 0 : 1; end
      chk("R7 no flush", cnt, 0);
      ack_n = 1'b0; tick(3); irq_n = 1'b1; tick(3); leave_mgmt();
    end

    // R3 soft reset outside the window
    srst_n = 1'b0; tick(2); chk("R3 early", srst_o, 0);
    tick(1); chk("R3 pulse", srst_o, 1);
    tick(1); chk("R3 width", srst_o, 0);
    cnt = 0;
    for (int j = 0; j < 5; j++) begin tick(1); cnt += srst_o; end
    chk("R3 held low", cnt, 0);
    srst_n = 1'b1; tick(4);

    // random outside management mode: R2 and R9
    p1 = a20_n; p2 = a20_n;
    for (int i = 0; i < 300; i++) begin
      logic ra, rh, rs;
      ra = 1'($urandom); rh = 1'($urandom); rs = 1'($urandom);
      a20_n = ra; hit = rh; snoop = rs;
      tick(1);
      chk("R9 outside", sel, exp_sel(1'b0, rh, rs));
      if (i >= 2) chk("R2 random", a20m_n, p2);
      p2 = p1; p1 = ra;
    end
    hit = 1'b0; snoop = 1'b0; a20_n = 1'b0;

    // random inside management mode: R1, R8, R9
    enter_mgmt();
    for (int i = 0; i < 300; i++) begin
      logic ra, rh, rs;
      ra = 1'($urandom); rh = 1'($urandom); rs = 1'($urandom);
      a20_n = ra; hit = rh; snoop = rs;
      tick(1);
      chk("R9/R8 inside", sel, exp_sel(1'b1, rh, rs));
      chk("R1 random", a20m_n, 1);
    end
    hit = 1'b0; snoop = 1'b0;

    // R10 reset discards a held request
    srst_pulse();
    rst = 1'b1; ack_n = 1'b1; tick(4); rst = 1'b0;
    cnt = 0;
    for (int j = 0; j < 8; j++) begin tick(1); cnt += srst_o; end
    chk("R10 pending cleared", cnt, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule